// File: doc/BRIEF.md
# Floppy Seek and Interrupt Status Unit

This unit keeps the present cylinder number of a single floppy drive and moves the head by emitting step pulses. A command sequencer upstream decodes host writes and hands this block one strobe per opcode byte and one strobe per parameter byte. Three seek flavours are supported: absolute, relative toward higher cylinders, and relative toward cylinder 0. When the head reaches its target, the unit latches a seek-end interrupt. The host retires that interrupt with the sense-interrupt-status command, and the unit answers it with a short queue of result bytes that the sequencer pops one at a time.

The unit also holds the sticky disk-change flag of the digital input register. The flag is set at reset and on every eject. Only a real step pulse taken while media is present clears it. Reading the flag has no effect on it, a seek that needs no step leaves it alone, and stepping an empty drive leaves it set.

Step spacing is set by a parameter, `STEP_GAP`, the number of clock cycles between pulses. Mechanical settle timing and multiple drives are not handled by this unit.

Top module: `fdc_seek_unit`

## Requirements
- R1: An absolute seek (opcode 0x0F; parameter bytes: unit, then target cylinder) leaves `pcn_o` at the target. It emits exactly |target - start| one-cycle `step_o` pulses, with `step_dir_o` = 1 on each pulse when moving to a higher cylinder and 0 when moving to a lower one.
- R2: `irq_o` is low from the cycle after a seek opcode is accepted until the last parameter byte has been taken. It rises after the seek completes, including a seek that needs no step.
- R3: A relative inward seek (opcode 0xCF) targets the present cylinder plus the second parameter byte, saturating at 255.
- R4: A relative outward seek (opcode 0x8F) targets the present cylinder minus the second parameter byte, saturating at 0.
- R5: Sense interrupt status (opcode 0x08) with no interrupt pending yields one result byte, 0x80, with `res_last_o` high on it.
- R6: Sense interrupt status after a completed seek yields two bytes. The first is ST0 = 0x20 OR bits [2:0] of the unit byte. The second is the present cylinder, with `res_last_o` high on it. The sense drops `irq_o`.
- R7: `disk_change_o` is 1 after reset and becomes 1 on the cycle after `eject_i`.
- R8: `disk_change_o` is not changed by being observed, nor by a seek that emits no step pulse.
- R9: A seek that emits at least one step pulse while `media_i` is high clears `disk_change_o`. Step pulses taken with `media_i` low leave it set.
- R10: A seek issued while a seek interrupt is still pending replaces the pending status: the next sense returns the new seek's ST0 and cylinder.
- R11: Opcodes other than 0x0F, 0xCF, 0x8F and 0x08, and parameter strobes that arrive while no command is collecting parameters, change neither `pcn_o` nor `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Opcode strobe |
| cmd_op_i | input | 8 | Opcode byte |
| param_valid_i | input | 1 | Parameter strobe |
| param_i | input | 8 | Parameter byte |
| res_pop_i | input | 1 | Consume the current result byte |
| media_i | input | 1 | Media present in drive |
| eject_i | input | 1 | Single-cycle eject event |
| pcn_o | output | 8 | Present cylinder number |
| step_o | output | 1 | Step pulse, one cycle |
| step_dir_o | output | 1 | Step direction, 1 = toward higher cylinder |
| busy_o | output | 1 | A seek is collecting parameters or stepping |
| irq_o | output | 1 | Seek-end interrupt pending |
| res_valid_o | output | 1 | A result byte is available |
| res_byte_o | output | 8 | Current result byte |
| res_last_o | output | 1 | Current result byte is the final one |
| disk_change_o | output | 1 | Sticky disk-change flag |

## Verification
The hardest case to reach is an overlap of two seeks. A second seek has to land while the first seek's interrupt is still unserviced, and the sense that follows must report only the newer status. The directed part of the bench therefore issues two seeks back to back with different unit bytes and no sense between them. The random phase interleaves seeks, senses, ejects and media insertions, so that pending-status replacement, saturation at both cylinder limits, and zero-step seeks on a flagged drive all recur in varied order.

// File: rtl/fdc_seek_pkg.sv
package fdc_seek_pkg;
  localparam logic [7:0] OP_SEEK      = 8'h0F;
  localparam logic [7:0] OP_RSEEK_IN  = 8'hCF;
  localparam logic [7:0] OP_RSEEK_OUT = 8'h8F;
  localparam logic [7:0] OP_SENSE     = 8'h08;

  localparam logic [7:0] ST0_SEEK_END = 8'h20;
  localparam logic [7:0] ST0_INVALID  = 8'h80;

  typedef enum logic [1:0] {SK_IDLE, SK_HDR, SK_CYL, SK_STEP} sk_state_e;
  typedef enum logic [1:0] {MV_ABS, MV_IN, MV_OUT} mv_kind_e;
endpackage

// File: rtl/fdc_seek_ctrl.sv
module fdc_seek_ctrl
  import fdc_seek_pkg::*;
#(
  parameter int CYL_W    = 8,
  parameter int STEP_GAP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_op_i,
  input  logic             param_valid_i,
  input  logic [7:0]       param_i,
  output logic [CYL_W-1:0] pcn_o,
  output logic             step_o,
  output logic             step_dir_o,
  output logic             busy_o,
  output logic             seek_start_o,
  output logic             sense_req_o,
  output logic             seek_done_o,
  output logic [2:0]       unit_o
);
  localparam int GAP_W = (STEP_GAP > 1) ? $clog2(STEP_GAP) : 1;
  localparam logic [CYL_W-1:0] CYL_MAX = '1;

  sk_state_e        state_q;
  mv_kind_e         kind_q;
  logic [2:0]       unit_q;
  logic [CYL_W-1:0] tgt_q, pcn_q, tgt_calc, arg;
  logic [GAP_W-1:0] gap_q;
  logic [CYL_W:0]   sum_w;
  logic             cmd_ok, is_seek, at_tgt, tick;

  assign arg     = param_i[CYL_W-1:0];
  assign cmd_ok  = cmd_valid_i && (state_q != SK_STEP);
  assign is_seek = (cmd_op_i == OP_SEEK) || (cmd_op_i == OP_RSEEK_IN) ||
                   (cmd_op_i == OP_RSEEK_OUT);
  assign seek_start_o = cmd_ok && is_seek;
  assign sense_req_o  = cmd_ok && (cmd_op_i == OP_SENSE);

  assign at_tgt      = (pcn_q == tgt_q);
  assign tick        = (state_q == SK_STEP) && (gap_q == '0);
  assign step_o      = tick && !at_tgt;
  assign step_dir_o  = (tgt_q > pcn_q);
  assign seek_done_o = tick && at_tgt;
  assign busy_o      = (state_q != SK_IDLE);
  assign pcn_o       = pcn_q;
  assign unit_o      = unit_q;

  // saturating target arithmetic
  always_comb begin
    sum_w = {1'b0, pcn_q} + {1'b0, arg};
    unique case (kind_q)
      MV_IN:   tgt_calc = sum_w[CYL_W] ? CYL_MAX : sum_w[CYL_W-1:0];
      MV_OUT:  tgt_calc = (arg > pcn_q) ? '0 : (pcn_q - arg);
      default: tgt_calc = arg;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SK_IDLE;
      kind_q  <= MV_ABS;
      unit_q  <= '0;
      tgt_q   <= '0;
      pcn_q   <= '0;
      gap_q   <= '0;
    end else if (seek_start_o) begin
      state_q <= SK_HDR;
      kind_q  <= (cmd_op_i == OP_RSEEK_IN)  ? MV_IN :
                 (cmd_op_i == OP_RSEEK_OUT) ? MV_OUT : MV_ABS;
    end else if (sense_req_o) begin
      state_q <= SK_IDLE;
    end else begin
      unique case (state_q)
        SK_HDR: if (param_valid_i) begin
          unit_q  <= param_i[2:0];
          state_q <= SK_CYL;
        end
        SK_CYL: if (param_valid_i) begin
          tgt_q   <= tgt_calc;
          gap_q   <= '0;
          state_q <= SK_STEP;
        end
        SK_STEP: begin
          if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
          end else if (!at_tgt) begin
            pcn_q <= step_dir_o ? pcn_q + 1'b1 : pcn_q - 1'b1;
            gap_q <= GAP_W'(STEP_GAP - 1);
          end else begin
            state_q <= SK_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  p_step_moves_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> pcn_q != $past(pcn_q));
  p_no_wrap_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && step_dir_o) |-> pcn_q != CYL_MAX);
  p_no_wrap_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !step_dir_o) |-> pcn_q != '0);
  p_idle_still_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SK_STEP) |=> pcn_q == $past(pcn_q));
endmodule

// File: rtl/fdc_irq_status.sv
module fdc_irq_status
  import fdc_seek_pkg::*;
#(
  parameter int CYL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seek_start_i,
  input  logic             seek_done_i,
  input  logic             sense_req_i,
  input  logic             res_pop_i,
  input  logic [2:0]       unit_i,
  input  logic [CYL_W-1:0] pcn_i,
  output logic             irq_o,
  output logic             res_valid_o,
  output logic [7:0]       res_byte_o,
  output logic             res_last_o
);
  logic       irq_q;
  logic [7:0] st0_q, cyl_q, b0_q, b1_q;
  logic [1:0] cnt_q;

  assign irq_o       = irq_q;
  assign res_valid_o = (cnt_q != 2'd0);
  assign res_byte_o  = b0_q;
  assign res_last_o  = (cnt_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      st0_q <= '0;
      cyl_q <= '0;
      b0_q  <= '0;
      b1_q  <= '0;
      cnt_q <= '0;
    end else if (seek_start_i) begin
      irq_q <= 1'b0;
      cnt_q <= '0;
    end else if (seek_done_i) begin
      irq_q <= 1'b1;
      st0_q <= ST0_SEEK_END | {5'd0, unit_i};
      cyl_q <= 8'(pcn_i);
    end else if (sense_req_i) begin
      if (irq_q) begin
        b0_q  <= st0_q;
        b1_q  <= cyl_q;
        cnt_q <= 2'd2;
        irq_q <= 1'b0;
      end else begin
        b0_q  <= ST0_INVALID;
        cnt_q <= 2'd1;
      end
    end else if (res_pop_i && cnt_q != 2'd0) begin
      cnt_q <= cnt_q - 1'b1;
      b0_q  <= b1_q;
    end
  end

  p_irq_low_params_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_start_i |=> !irq_q);
  p_irq_on_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seek_done_i |=> irq_q);
  p_sense_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_req_i |=> !irq_q && res_valid_o);
  p_idle_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_req_i && !irq_q) |=> res_byte_o == ST0_INVALID && res_last_o);
endmodule

// File: rtl/fdc_dskchg.sv
module fdc_dskchg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eject_i,
  input  logic step_i,
  input  logic media_i,
  output logic disk_change_o
);
  logic dc_q;
  assign disk_change_o = dc_q;

  // eject wins over a coincident step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 dc_q <= 1'b1;
    else if (eject_i)            dc_q <= 1'b1;
    else if (step_i && media_i)  dc_q <= 1'b0;
  end

  p_eject_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eject_i |=> dc_q);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_q && !step_i) |=> dc_q);
  p_empty_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_q && step_i && !media_i) |=> dc_q);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && media_i && !eject_i) |=> !dc_q);
endmodule

// File: rtl/fdc_seek_unit.sv
module fdc_seek_unit
  import fdc_seek_pkg::*;
#(
  parameter int CYL_W    = 8,
  parameter int STEP_GAP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_op_i,
  input  logic             param_valid_i,
  input  logic [7:0]       param_i,
  input  logic             res_pop_i,
  input  logic             media_i,
  input  logic             eject_i,
  output logic [CYL_W-1:0] pcn_o,
  output logic             step_o,
  output logic             step_dir_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             res_valid_o,
  output logic [7:0]       res_byte_o,
  output logic             res_last_o,
  output logic             disk_change_o
);
  logic       seek_start, sense_req, seek_done, step_w;
  logic [2:0] unit_w;

  assign step_o = step_w;

  fdc_seek_ctrl #(.CYL_W(CYL_W), .STEP_GAP(STEP_GAP)) u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .param_valid_i, .param_i,
    .pcn_o, .step_o(step_w), .step_dir_o, .busy_o,
    .seek_start_o(seek_start), .sense_req_o(sense_req),
    .seek_done_o(seek_done), .unit_o(unit_w)
  );

  fdc_irq_status #(.CYL_W(CYL_W)) u_status (
    .clk_i, .rst_ni, .seek_start_i(seek_start), .seek_done_i(seek_done),
    .sense_req_i(sense_req), .res_pop_i, .unit_i(unit_w), .pcn_i(pcn_o),
    .irq_o, .res_valid_o, .res_byte_o, .res_last_o
  );

  fdc_dskchg u_dskchg (
    .clk_i, .rst_ni, .eject_i, .step_i(step_w), .media_i, .disk_change_o
  );
endmodule

// File: tb/fdc_seek_unit_bench.sv
module fdc_seek_unit_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 0, param_valid = 0, res_pop = 0, media = 0, eject = 0;
  logic [7:0] cmd_op = 0, param = 0;
  logic [7:0] pcn, res_byte;
  logic       step, step_dir, busy, irq, res_valid, res_last, dchg;

  int n_tests = 0, n_fail = 0;
  int step_cnt = 0, up_cnt = 0;
  int m_pcn = 0, m_irq = 0, m_st0 = 0, m_cyl = 0, m_dc = 1;
  bit done = 0;

  always #5 clk = ~clk;

  fdc_seek_unit u_fdc_seek_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .param_valid_i(param_valid), .param_i(param), .res_pop_i(res_pop),
    .media_i(media), .eject_i(eject), .pcn_o(pcn), .step_o(step),
    .step_dir_o(step_dir), .busy_o(busy), .irq_o(irq), .res_valid_o(res_valid),
    .res_byte_o(res_byte), .res_last_o(res_last), .disk_change_o(dchg)
  );

  always @(negedge clk) if (step) begin
    step_cnt++;
    if (step_dir) up_cnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int calc_tgt(input int op, input int cur, input int v);
    int t;
    if (op == 8'hCF) t = (cur + v > 255) ? 255 : cur + v;
    else if (op == 8'h8F) t = (v > cur) ? 0 : cur - v;
    else t = v;
    return t;
  endfunction

  task automatic send_cmd(input logic [7:0] op);
    @(negedge clk); cmd_valid = 1; cmd_op = op;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic send_param(input logic [7:0] b);
    @(negedge clk); param_valid = 1; param = b;
    @(negedge clk); param_valid = 0;
  endtask

  task automatic pop;
    @(negedge clk); res_pop = 1;
    @(negedge clk); res_pop = 0;
  endtask

  task automatic do_seek(input logic [7:0] op, input int unit, input int v, input string req);
    int tgt, diff, k;
    tgt = calc_tgt(op, m_pcn, v);
    diff = (tgt > m_pcn) ? tgt - m_pcn : m_pcn - tgt;
    step_cnt = 0; up_cnt = 0;
    send_cmd(op);
    check(irq == 0, "R2", irq, 0);
    send_param(8'(unit));
    check(irq == 0, "R2", irq, 0);
    send_param(8'(v));
    k = 0;
    while (!irq && k < 2000) begin @(negedge clk); k++; end
    check(irq == 1, "R2", irq, 1);
    check(int'(pcn) == tgt, req, pcn, tgt);
    check(step_cnt == diff, "R1", step_cnt, diff);
    check(up_cnt == ((tgt > m_pcn) ? diff : 0), "R1", up_cnt, (tgt > m_pcn) ? diff : 0);
    if (diff > 0 && media) m_dc = 0;
    check(int'(dchg) == m_dc, (diff == 0) ? "R8" : "R9", dchg, m_dc);
    m_pcn = tgt; m_irq = 1; m_st0 = 8'h20 | (unit & 7); m_cyl = tgt;
  endtask

  task automatic do_sense(input string req);
    send_cmd(8'h08);
    check(irq == 0, "R6", irq, 0);
    if (m_irq) begin
      check(res_valid && int'(res_byte) == m_st0 && !res_last, req, res_byte, m_st0);
      pop();
      check(res_valid && int'(res_byte) == m_cyl && res_last, req, res_byte, m_cyl);
      pop();
    end else begin
      check(res_valid && res_byte == 8'h80 && res_last, "R5", res_byte, 8'h80);
      pop();
    end
    check(!res_valid, req, res_valid, 0);
    m_irq = 0;
  endtask

  task automatic do_eject;
    @(negedge clk); eject = 1; media = 0;
    @(negedge clk); eject = 0;
    m_dc = 1;
    check(dchg == 1, "R7", dchg, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check(pcn == 0 && !irq && !busy && !res_valid, "R1", {pcn, irq, busy}, 0);
    check(dchg == 1, "R7", dchg, 1);

    do_sense("R5");

    // unknown opcode, stray parameters: R11
    send_cmd(8'h4A);
    send_param(8'h00);
    send_param(8'h05);
    repeat (10) @(negedge clk);
    check(pcn == 0 && !irq && !busy, "R11", {pcn, irq}, 0);

    // steps on empty drive keep flag: R9
    do_seek(8'h0F, 0, 3, "R1");
    do_sense("R6");
    // insert media, zero-step seek keeps flag: R8
    media = 1;
    do_seek(8'h0F, 0, 3, "R1");
    repeat (5) @(negedge clk);
    check(dchg == 1, "R8", dchg, 1);
    do_sense("R6");
    // outward below zero saturates, step with media clears flag
    do_seek(8'h8F, 0, 10, "R4");
    check(dchg == 0, "R9", dchg, 0);
    do_seek(8'hCF, 1, 250, "R3");
    do_seek(8'hCF, 1, 20, "R3");
    check(pcn == 8'd255, "R3", pcn, 255);
    // overlapping seeks: R10
    do_seek(8'h0F, 5, 10, "R1");
    do_seek(8'h0F, 2, 7, "R10");
    do_sense("R10");
    do_eject();

    for (int i = 0; i < 60; i++) begin
      int r;
      r = int'($urandom % 6);
      case (r)
        0: do_seek(8'h0F, int'($urandom % 8), int'($urandom % 256), "R1");
        1: do_seek(8'hCF, int'($urandom % 8), int'($urandom % 64), "R3");
        2: do_seek(8'h8F, int'($urandom % 8), int'($urandom % 64), "R4");
        3: do_sense(m_irq ? "R6" : "R5");
        4: do_eject();
        default: begin @(negedge clk); media = 1; end
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule